// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends characters on a single serial line in the usual asynchronous format. The line rests at mark (high). Each frame has a low start bit, then 7, 8 or 9 data bits starting with the least significant bit, then an optional even or odd parity bit, then one or two high stop bits. A holding register sits in front of the frame shifter. Software can therefore queue the next character while the current one is still going out.

The shifter takes a character from the holding register only at a frame boundary. A transfer needs three things: the enable input is high, the holding register is full and, when flow control is selected, the clear-to-send input is low. After a frame has begun it always runs to the end of its stop bits, whatever those inputs do meanwhile. If the next character is ready when the last stop bit ends, its start bit follows at once, with no idle time in between.

A bit lasts 16 × (n+1) clock periods, where n is the baud divisor input. Three status outputs report progress:
- a holding-register-empty flag;
- a line-idle flag, which rises one clock after the frame boundary;
- a one-cycle interrupt pulse each time a character leaves the holding register.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `tx_empty` is 1 and `tx_irq` is 0.
- R2: A character is taken from the holding register only when `tx_enable` is 1, the register is full, and either `cts_select` is 0 or `cts_n` is 0. If any of these fails, the line stays at mark and the character stays pending.
- R3: A frame is a 0 start bit, then the data bits least significant first, then the stop bits at 1. `len_sel` selects the data length: 00 gives 7 bits, 01 gives 8 bits, 10 or 11 gives 9 bits. `two_stop` = 1 gives two stop bits.
- R4: When `parity_en` is 1, one parity bit follows the data. It is the XOR of the data bits in use, inverted when `parity_odd` is 1.
- R5: Each bit lasts exactly 16 × (`baud_div` + 1) clock cycles. The start bit is driven in the first cycle after the transfer edge.
- R6: A write sets `buf_empty` to 0 on the next cycle. A transfer into the shifter sets it back to 1, unless a write arrives in the same cycle.
- R7: `tx_irq` is high for exactly one cycle each time `buf_empty` goes from 0 to 1.
- R8: `tx_empty` rises one cycle after the last stop bit ends when no new frame starts. It falls when a transfer starts a frame.
- R9: Once a frame has started, dropping `tx_enable` or raising `cts_n` does not shorten or change it.
- R10: If a character is pending when the last stop bit ends, the next start bit begins in the very next cycle, and `tx_empty` stays 0.
- R11: A write while the holding register is full replaces the pending character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the bit-rate source |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_enable | input | 1 | Permits new frames to start |
| cts_select | input | 1 | 1 makes `cts_n` gate frame starts |
| cts_n | input | 1 | Clear-to-send, active low |
| len_sel | input | 2 | Data length: 00=7, 01=8, 1x=9 |
| parity_en | input | 1 | Adds a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| two_stop | input | 1 | 1 = two stop bits |
| baud_div | input | DIV_W | Divisor n; bit time 16×(n+1) cycles |
| wr_en | input | 1 | Writes `wr_data` into the holding register |
| wr_data | input | 9 | Character to send |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | No frame in progress and none pending on the line |
| tx_irq | output | 1 | One-cycle pulse when the holding register empties |

## Verification
A write at clock edge E0 clears `buf_empty` after E0. If the start condition holds, the transfer happens at E1. After E1, `buf_empty`, `tx_irq`, `tx_empty` and the start bit on `txd` all change together.

Bit k of a frame occupies the cycles from E1 + k·B to E1 + (k+1)·B, where B = 16(n+1). Each scenario task counts falling clock edges from the cycle after E1 and samples bit k in its middle. It also samples the last cycle of the start bit and the first cycle of data bit 0, which catches any error in the bit length. `tx_empty` and the next start bit are checked at exactly N·B cycles after E1, where N is the number of frame bits.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   localparam int MAX_DATA = 9;
   localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;
   localparam int CNT_W    = $clog2(FRAME_W + 1);

   typedef enum logic [1:0] {
      LEN_7  = 2'b00,
      LEN_8  = 2'b01,
      LEN_9  = 2'b10,
      LEN_9B = 2'b11
   } len_e;

   function automatic logic [3:0] data_len(input logic [1:0] sel);
      case (len_e'(sel))
         LEN_7:   data_len = 4'd7;
         LEN_8:   data_len = 4'd8;
         default: data_len = 4'd9;
      endcase
   endfunction
endpackage

// File: rtl/sertx_frame.sv
module sertx_frame
   import sertx_pkg::*;
(
   input  logic [MAX_DATA-1:0] data,
   input  logic [1:0]          len_sel,
   input  logic                parity_en,
   input  logic                parity_odd,
   input  logic                two_stop,
   output logic [FRAME_W-1:0]  frm,
   output logic [CNT_W-1:0]    nbits
);
   logic [3:0]          dlen;
   logic [MAX_DATA-1:0] dmask;
   logic                par_bit;

   assign dlen = data_len(len_sel);

   for (genvar i = 0; i < MAX_DATA; i++) begin : g_mask
      assign dmask[i] = (4'(i) < dlen);
   end

   assign par_bit = (^(data & dmask)) ^ parity_odd;

   always_comb begin
      frm    = '1;
      frm[0] = 1'b0;
      for (int i = 0; i < MAX_DATA; i++) begin
         if (dmask[i]) frm[i+1] = data[i];
      end
      if (parity_en) frm[dlen + 4'd1] = par_bit;
   end

   assign nbits = CNT_W'(4'd2 + dlen + {3'b0, parity_en} + {3'b0, two_stop});
endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
   parameter int DIV_W = 8,
   parameter int OVS   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             bit_end
);
   localparam int SUB_W = $clog2(OVS);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

   logic [DIV_W-1:0] pre;
   logic [SUB_W-1:0] sub, sub_next;
   logic             pre_wrap, sub_last;

   assign pre_wrap = (pre == div);
   assign sub_last = (sub == SUB_LAST);

   if ((OVS & (OVS - 1)) == 0) begin : g_pow2
      assign sub_next = sub + 1'b1;
   end else begin : g_mod
      assign sub_next = sub_last ? '0 : sub + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre <= '0;
         sub <= '0;
      end else if (restart || !run) begin
         pre <= '0;
         sub <= '0;
      end else if (pre_wrap) begin
         pre <= '0;
         sub <= sub_next;
      end else begin
         pre <= pre + 1'b1;
      end
   end

   assign bit_end = run && pre_wrap && sub_last;
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          take,
   output logic [DW-1:0] hold_data,
   output logic          empty,
   output logic          irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_data <= '0;
         empty     <= 1'b1;
         irq       <= 1'b0;
      end else begin
         irq <= take && !wr_en;
         if (wr_en) begin
            hold_data <= wr_data;
            empty     <= 1'b0;
         end else if (take) begin
            empty     <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
   parameter int FW = 13,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          frame_end,
   input  logic          bit_end,
   input  logic [FW-1:0] frm,
   input  logic [CW-1:0] nbits,
   output logic          txd,
   output logic          busy,
   output logic          last,
   output logic          tx_empty
);
   logic [FW-1:0] shreg;
   logic [CW-1:0] bits_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '1;
         bits_left <= '0;
         busy      <= 1'b0;
         tx_empty  <= 1'b1;
      end else if (start) begin
         shreg     <= frm;
         bits_left <= nbits - 1'b1;
         busy      <= 1'b1;
         tx_empty  <= 1'b0;
      end else begin
         if (frame_end) tx_empty <= 1'b1;
         if (busy && bit_end) begin
            if (bits_left == '0) begin
               busy <= 1'b0;
            end else begin
               shreg     <= {1'b1, shreg[FW-1:1]};
               bits_left <= bits_left - 1'b1;
            end
         end
      end
   end

   assign txd  = shreg[0];
   assign last = (bits_left == '0);
endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf
   import sertx_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int OVS   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_enable,
   input  logic                cts_select,
   input  logic                cts_n,
   input  logic [1:0]          len_sel,
   input  logic                parity_en,
   input  logic                parity_odd,
   input  logic                two_stop,
   input  logic [DIV_W-1:0]    baud_div,
   input  logic                wr_en,
   input  logic [MAX_DATA-1:0] wr_data,
   output logic                txd,
   output logic                buf_empty,
   output logic                tx_empty,
   output logic                tx_irq
);
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("sertx_dbuf: DIV_W must lie in 1..16");
   end
   if (OVS < 2) begin : g_bad_ovs
      $error("sertx_dbuf: OVS must be at least 2");
   end

   logic [MAX_DATA-1:0] hold_data;
   logic [FRAME_W-1:0]  frm;
   logic [CNT_W-1:0]    nbits;
   logic                busy, last, bit_end, frame_end, start_go;

   assign frame_end = !busy || (last && bit_end);
   assign start_go  = frame_end && tx_enable && !buf_empty
                      && (!cts_select || !cts_n);

   sertx_hold #(.DW(MAX_DATA)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .take      (start_go),
      .hold_data (hold_data),
      .empty     (buf_empty),
      .irq       (tx_irq)
   );

   sertx_frame u_frame (
      .data       (hold_data),
      .len_sel    (len_sel),
      .parity_en  (parity_en),
      .parity_odd (parity_odd),
      .two_stop   (two_stop),
      .frm        (frm),
      .nbits      (nbits)
   );

   sertx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .restart (start_go),
      .div     (baud_div),
      .bit_end (bit_end)
   );

   sertx_shift #(.FW(FRAME_W), .CW(CNT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_go),
      .frame_end (frame_end),
      .bit_end   (bit_end),
      .frm       (frm),
      .nbits     (nbits),
      .txd       (txd),
      .busy      (busy),
      .last      (last),
      .tx_empty  (tx_empty)
   );
endmodule

// File: rtl/sertx_dbuf_chk.sv
module sertx_dbuf_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_enable,
   input logic cts_select,
   input logic cts_n,
   input logic wr_en,
   input logic txd,
   input logic buf_empty,
   input logic tx_empty,
   input logic tx_irq,
   input logic busy,
   input logic frame_end
);
   a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> (txd && !busy));

   a_r2_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_empty) |-> ($past(tx_enable) && (!$past(cts_select) || !$past(cts_n))));

   a_r6_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !buf_empty);

   a_r7_irq_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> $rose(buf_empty));

   a_r7_rise_gives_irq: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_empty) |-> tx_irq);

   a_r8_txe_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty) |-> $past(frame_end));

   a_r8_start_drops_txe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_empty) |-> !txd);

   a_r9_frame_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !frame_end) |=> busy);

   a_r10_gapless: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && frame_end && !buf_empty && tx_enable && (!cts_select || !cts_n))
      |=> (busy && !txd && !tx_empty));
endmodule

bind sertx_dbuf sertx_dbuf_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_enable  (tx_enable),
   .cts_select (cts_select),
   .cts_n      (cts_n),
   .wr_en      (wr_en),
   .txd        (txd),
   .buf_empty  (buf_empty),
   .tx_empty   (tx_empty),
   .tx_irq     (tx_irq),
   .busy       (busy),
   .frame_end  (frame_end)
);

// File: tb/sertx_dbuf_tb.sv
module sertx_dbuf_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_enable = 1'b0, cts_select = 1'b0, cts_n = 1'b1;
   logic [1:0] len_sel = 2'b01;
   logic       parity_en = 1'b0, parity_odd = 1'b0, two_stop = 1'b0;
   logic [7:0] baud_div = 8'd0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_data = '0;
   logic       txd, buf_empty, tx_empty, tx_irq;
   int         nchk = 0, nfail = 0;

   always #5 clk = ~clk;

   sertx_dbuf u_dut (
      .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .cts_select(cts_select),
      .cts_n(cts_n), .len_sel(len_sel), .parity_en(parity_en),
      .parity_odd(parity_odd), .two_stop(two_stop), .baud_div(baud_div),
      .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .buf_empty(buf_empty),
      .tx_empty(tx_empty), .tx_irq(tx_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int cur_len();
      return (len_sel == 2'b00) ? 7 : (len_sel == 2'b01) ? 8 : 9;
   endfunction

   function automatic int exp_n();
      return 2 + cur_len() + int'(parity_en) + int'(two_stop);
   endfunction

   function automatic logic exp_bit(input logic [8:0] d, input int k);
      int  l = cur_len();
      logic p = parity_odd;
      for (int i = 0; i < l; i++) p ^= d[i];
      if (k == 0) return 1'b0;
      if (k <= l) return d[k-1];
      if (parity_en && k == l + 1) return p;
      return 1'b1;
   endfunction

   task automatic do_write(input logic [8:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   // Called one negedge after the transfer edge (t = 0); returns at t = N*B.
   task automatic run_frame(input logic [8:0] d, input int n, input bit idle_after, input string tg);
      int b = 16 * (n + 1);
      int nb = exp_n();
      chk({tg, " R6 empty after transfer"}, buf_empty, 1);
      chk({tg, " R7 irq at transfer"}, tx_irq, 1);
      chk({tg, " R8 txe low in frame"}, tx_empty, 0);
      chk({tg, " R3 start bit"}, txd, 0);
      repeat (b/2) @(negedge clk);
      chk({tg, " R3 start mid"}, txd, 0);
      chk({tg, " R7 irq one cycle"}, tx_irq, 0);
      repeat (b/2 - 1) @(negedge clk);
      chk({tg, " R5 start last cycle"}, txd, 0);
      @(negedge clk);
      chk({tg, " R5 data0 first cycle"}, txd, exp_bit(d, 1));
      repeat (b/2) @(negedge clk);
      chk({tg, " R3 data0"}, txd, exp_bit(d, 1));
      for (int k = 2; k < nb; k++) begin
         repeat (b) @(negedge clk);
         if (parity_en && k == cur_len() + 1)
            chk({tg, " R4 parity bit"}, txd, exp_bit(d, k));
         else
            chk({tg, " R3 frame bit"}, txd, exp_bit(d, k));
      end
      repeat (b/2) @(negedge clk);
      if (idle_after) begin
         chk({tg, " R8 txe after end"}, tx_empty, 1);
         chk({tg, " R1 line at mark"}, txd, 1);
      end
   endtask

   task automatic t_reset();
      chk("R1 txd", txd, 1);
      chk("R1 buf_empty", buf_empty, 1);
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 tx_irq", tx_irq, 0);
   endtask

   task automatic t_format(input logic [1:0] ls, input bit pe, input bit po,
                           input bit ts, input int n, input logic [8:0] d, input string tg);
      len_sel = ls; parity_en = pe; parity_odd = po; two_stop = ts;
      baud_div = 8'(n); tx_enable = 1'b1;
      do_write(d);
      chk({tg, " R6 write fills"}, buf_empty, 0);
      @(negedge clk);
      run_frame(d, n, 1'b1, tg);
   endtask

   task automatic t_cts();
      len_sel = 2'b01; parity_en = 0; two_stop = 0; baud_div = 0;
      tx_enable = 1'b1; cts_select = 1'b1; cts_n = 1'b1;
      do_write(9'h05A);
      repeat (40) @(negedge clk);
      chk("R2 cts high holds line", txd, 1);
      chk("R2 cts high keeps pending", buf_empty, 0);
      chk("R2 cts high idle", tx_empty, 1);
      cts_n = 1'b0;
      @(negedge clk);
      fork
         run_frame(9'h05A, 0, 1'b1, "cts R9");
         begin repeat (30) @(negedge clk); cts_n = 1'b1; end
      join
      cts_select = 1'b0;
   endtask

   task automatic t_hold();
      len_sel = 2'b01; parity_en = 1; parity_odd = 0; two_stop = 0; baud_div = 0;
      tx_enable = 1'b1;
      do_write(9'h03C);
      @(negedge clk);
      fork
         run_frame(9'h03C, 0, 1'b1, "en drop R9");
         begin repeat (25) @(negedge clk); tx_enable = 1'b0; end
      join
      do_write(9'h011);
      do_write(9'h096);
      repeat (30) @(negedge clk);
      chk("R2 disabled line mark", txd, 1);
      chk("R2 disabled keeps pending", buf_empty, 0);
      chk("R2 disabled idle", tx_empty, 1);
      tx_enable = 1'b1;
      @(negedge clk);
      run_frame(9'h096, 0, 1'b1, "R11 overwrite");
   endtask

   task automatic t_b2b();
      len_sel = 2'b00; parity_en = 1; parity_odd = 1; two_stop = 1; baud_div = 8'd1;
      tx_enable = 1'b1;
      do_write(9'h04B);
      @(negedge clk);
      fork
         run_frame(9'h04B, 1, 1'b0, "b2b first");
         begin repeat (20) @(negedge clk); do_write(9'h027); end
      join
      chk("R10 next start immediate", txd, 0);
      chk("R10 txe stays low", tx_empty, 0);
      run_frame(9'h027, 1, 1'b1, "b2b second R10");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_format(2'b01, 0, 0, 0, 0, 9'h0A5, "8N1");
      t_format(2'b00, 1, 0, 1, 1, 9'h035, "7E2");
      t_format(2'b10, 1, 1, 1, 2, 9'h1C3, "9O2");
      t_format(2'b11, 1, 0, 0, 0, 9'h0F1, "9E1");
      t_cts();
      t_hold();
      t_b2b();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule